// File: doc/BRIEF.md
# Segment Base and Limit Unit with Switchable Address Mode

This unit turns a segment tag and an offset into a linear address. A mode input picks one of two rule sets. In legacy 32-bit mode every segment adds its base, and the access is checked against that segment's limit. In 64-bit mode the code, data, extra and stack segments give a base of zero, and no limit applies. Only the two thread and CPU-local segments (FS and GS) still add a base in 64-bit mode.

The unit holds three base registers: FS, GS and a kernel-side GS shadow. Software-facing logic can write any of them directly, with no descriptor load. A swap command exchanges the live GS base and the kernel GS shadow in one clock edge, as happens on kernel entry and exit. The bases of the four legacy segments and the limits of all six segments come in from a descriptor cache outside this unit. Each result comes out registered, one cycle after its request.

Top module: `seg_base_unit`

## Requirements
- R1: Reset clears the FS, GS and kernel GS base registers to zero, and holds `addr_valid`, `lim_fault` and `lin_addr` at zero.
- R2: In 64-bit mode (`mode64`=1), a request to ES (tag 0), CS (1), SS (2) or DS (3) yields `lin_addr` equal to the offset, whatever `legacy_base` holds.
- R3: In 64-bit mode, a request to FS (tag 4) or GS (tag 5) yields the held base plus the offset, modulo 2^ADDR_W.
- R4: In 64-bit mode, a request with a valid tag never raises `lim_fault`, whatever the limits, offset and size.
- R5: In 32-bit mode, every valid tag adds its base to the offset: `legacy_base[tag]` for tags 0 to 3, and the held FS or GS register for tags 4 and 5. The sum is truncated to 32 bits and zero-extended.
- R6: In 32-bit mode, when the 32-bit offset plus `acc_size` minus one is greater than `seg_limit[tag]`, `lim_fault` is 1 and `addr_valid` is 0. An access that ends exactly at the limit is accepted. `addr_valid` and `lim_fault` are never both 1.
- R7: A write (`base_wr_en`) with `base_wr_sel` 0 = FS, 1 = GS, 2 = kernel GS loads `base_wr_data` into that register. A request sees the new value from the next cycle on. A request in the same cycle still sees the old value.
- R8: `swap_gs` exchanges the GS and kernel GS bases in a single edge. Swapping twice restores both registers.
- R9: When a write and a swap fall in the same cycle, the swap happens first and the write then lands in the register it selects, after the swap.
- R10: Results appear one cycle after the request. A cycle without `req_valid` gives `addr_valid`=0, `lim_fault`=0 and `lin_addr`=0 in the next cycle. A faulting request also gives `lin_addr`=0.
- R11: A tag of 6 or 7 raises `lim_fault` in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 = 64-bit rules, 0 = 32-bit rules |
| req_valid | input | 1 | A translation request is present |
| seg_sel | input | 3 | Segment tag: ES=0, CS=1, SS=2, DS=3, FS=4, GS=5 |
| offset | input | ADDR_W | Effective offset |
| acc_size | input | SIZE_W | Access size in bytes, 1 or more |
| legacy_base | input | 4 x ADDR_W | Bases of tags 0 to 3, indexed by tag |
| seg_limit | input | 6 x LIM_W | Limits of tags 0 to 5, indexed by tag |
| base_wr_en | input | 1 | Direct base register write |
| base_wr_sel | input | 2 | 0 = FS, 1 = GS, 2 = kernel GS |
| base_wr_data | input | ADDR_W | Write value |
| swap_gs | input | 1 | Exchange GS and kernel GS |
| lin_addr | output | ADDR_W | Linear address (registered) |
| addr_valid | output | 1 | `lin_addr` holds a good address |
| lim_fault | output | 1 | Limit violation or bad tag |

## Verification
The kernel GS shadow has no path of its own to the outputs. Its contents show only once a swap has moved them into the live GS slot and a GS request has read them. The stimulus therefore loads GS and the shadow with distinct values, swaps, and requests GS after each swap. It also makes a swap and a GS write collide in one cycle, then swaps again to expose what the shadow received. The limit boundary is covered by an access ending exactly on the limit and by one that crosses it by a byte. Nonzero legacy bases are kept loaded throughout the 64-bit checks, so that a base which wrongly leaks through changes the address.

// File: rtl/seg_base_unit.sv
module seg_base_unit #(
  parameter int ADDR_W = 64,
  parameter int LIM_W  = 32,
  parameter int SIZE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode64,
  input  logic                         req_valid,
  input  logic [2:0]                   seg_sel,
  input  logic [ADDR_W-1:0]            offset,
  input  logic [SIZE_W-1:0]            acc_size,
  input  logic [3:0][ADDR_W-1:0]       legacy_base,
  input  logic [5:0][LIM_W-1:0]        seg_limit,
  input  logic                         base_wr_en,
  input  logic [1:0]                   base_wr_sel,
  input  logic [ADDR_W-1:0]            base_wr_data,
  input  logic                         swap_gs,
  output logic [ADDR_W-1:0]            lin_addr,
  output logic                         addr_valid,
  output logic                         lim_fault
);
  localparam logic [2:0] TAG_FS = 3'd4;
  localparam logic [2:0] TAG_GS = 3'd5;
  localparam logic [1:0] WR_FS  = 2'd0;
  localparam logic [1:0] WR_GS  = 2'd1;
  localparam logic [1:0] WR_KGS = 2'd2;
  localparam int EXT_W = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] fs_base, gs_base, kgs_base;
  logic [ADDR_W-1:0] gs_post, kgs_post;
  logic [ADDR_W-1:0] raw_base, eff_base, sum, addr_d;
  logic [LIM_W:0]    last_byte;
  logic [LIM_W-1:0]  lim_sel;
  logic [2:0]        lim_idx;
  logic              tag_ok, flat_seg, over, ok_d, bad_d;

  assign tag_ok   = seg_sel <= TAG_GS;
  assign flat_seg = ~seg_sel[2];
  assign lim_idx  = tag_ok ? seg_sel : 3'd0;
  assign lim_sel  = seg_limit[lim_idx];

  always_comb begin
    case (seg_sel)
      TAG_FS:  raw_base = fs_base;
      TAG_GS:  raw_base = gs_base;
      default: raw_base = legacy_base[seg_sel[1:0]];
    endcase
  end

  assign eff_base  = (mode64 && flat_seg) ? '0 : raw_base;
  assign sum       = eff_base + offset;
  assign last_byte = {1'b0, offset[LIM_W-1:0]} + (LIM_W+1)'(acc_size) - (LIM_W+1)'(1);
  assign over      = !mode64 && (last_byte > {1'b0, lim_sel});
  assign addr_d    = mode64 ? sum : {{EXT_W{1'b0}}, sum[LIM_W-1:0]};
  assign ok_d      = req_valid && tag_ok && !over;
  assign bad_d     = req_valid && (!tag_ok || over);

  assign gs_post  = swap_gs ? kgs_base : gs_base;
  assign kgs_post = swap_gs ? gs_base  : kgs_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_base  <= '0;
      gs_base  <= '0;
      kgs_base <= '0;
    end else begin
      fs_base  <= (base_wr_en && base_wr_sel == WR_FS)  ? base_wr_data : fs_base;
      gs_base  <= (base_wr_en && base_wr_sel == WR_GS)  ? base_wr_data : gs_post;
      kgs_base <= (base_wr_en && base_wr_sel == WR_KGS) ? base_wr_data : kgs_post;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_addr   <= '0;
      addr_valid <= 1'b0;
      lim_fault  <= 1'b0;
    end else begin
      lin_addr   <= ok_d ? addr_d : '0;
      addr_valid <= ok_d;
      lim_fault  <= bad_d;
    end
  end
endmodule

// File: rtl/seg_base_unit_chk.sv
module seg_base_unit_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode64,
  input logic              req_valid,
  input logic [2:0]        seg_sel,
  input logic [ADDR_W-1:0] offset,
  input logic              base_wr_en,
  input logic              swap_gs,
  input logic [ADDR_W-1:0] gs_base,
  input logic [ADDR_W-1:0] kgs_base,
  input logic [ADDR_W-1:0] lin_addr,
  input logic              addr_valid,
  input logic              lim_fault
);
  // R6
  valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && lim_fault));

  // R2
  flat_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode64 && seg_sel < 3'd4) |=> (addr_valid && lin_addr == $past(offset)));

  // R4
  no_limit64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode64 && seg_sel < 3'd6) |=> !lim_fault);

  // R8
  gs_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_gs && !base_wr_en) |=> (gs_base == $past(kgs_base) && kgs_base == $past(gs_base)));

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && !lim_fault && lin_addr == '0));

  // R11
  bad_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_sel > 3'd5) |=> lim_fault);
endmodule

bind seg_base_unit seg_base_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/seg_base_unit_bench.sv
module seg_base_unit_bench;
  localparam int AW = 64;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode64 = 1'b0, req_valid = 1'b0, base_wr_en = 1'b0, swap_gs = 1'b0;
  logic [2:0] seg_sel = '0;
  logic [AW-1:0] offset = '0, base_wr_data = '0;
  logic [3:0] acc_size = 4'd1;
  logic [3:0][AW-1:0] legacy_base;
  logic [5:0][LW-1:0] seg_limit;
  logic [1:0] base_wr_sel = '0;
  logic [AW-1:0] lin_addr;
  logic addr_valid, lim_fault;

  always #2 clk = ~clk;

  seg_base_unit u_seg_base_unit (.*);

  typedef struct {
    int cyc;
    logic [AW-1:0] a;
    bit v;
    bit f;
    string rq;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] m_fs = '0, m_gs = '0, m_kgs = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc == cyc - 1) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lin_addr !== e.a || addr_valid !== e.v || lim_fault !== e.f) begin
        errors++;
        $display("FAIL %s: got addr=%h v=%b f=%b, expected addr=%h v=%b f=%b",
                 e.rq, lin_addr, addr_valid, lim_fault, e.a, e.v, e.f);
      end
    end
  end

  task automatic step(input bit m64, input bit v, input logic [2:0] tag,
                      input logic [AW-1:0] off, input logic [3:0] sz,
                      input bit wr, input logic [1:0] wsel, input logic [AW-1:0] wd,
                      input bit swp, input string rq);
    exp_t e;
    logic [AW-1:0] base;
    logic [LW:0] last;
    @(negedge clk);
    mode64 = m64; req_valid = v; seg_sel = tag; offset = off; acc_size = sz;
    base_wr_en = wr; base_wr_sel = wsel; base_wr_data = wd; swap_gs = swp;
    e.cyc = cyc; e.rq = rq; e.a = '0; e.v = 0; e.f = 0;
    if (v) begin
      if (tag > 3'd5) e.f = 1;
      else begin
        base = (tag == 3'd4) ? m_fs : (tag == 3'd5) ? m_gs : legacy_base[tag[1:0]];
        if (m64) begin
          if (tag < 3'd4) base = '0;
          e.a = base + off; e.v = 1;
        end else begin
          last = {1'b0, off[LW-1:0]} + 33'(sz) - 33'd1;
          if (last > {1'b0, seg_limit[tag]}) e.f = 1;
          else begin
            e.a = {32'd0, 32'(base + off)}; e.v = 1;
          end
        end
      end
    end
    q.push_back(e);
    if (swp) begin base = m_gs; m_gs = m_kgs; m_kgs = base; end
    if (wr) begin
      if (wsel == 2'd0) m_fs = wd;
      else if (wsel == 2'd1) m_gs = wd;
      else if (wsel == 2'd2) m_kgs = wd;
    end
  endtask

  task automatic req(input bit m64, input logic [2:0] tag, input logic [AW-1:0] off,
                     input logic [3:0] sz, input string rq);
    step(m64, 1, tag, off, sz, 0, 2'd0, '0, 0, rq);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d, input string rq);
    step(0, 0, 3'd0, '0, 4'd1, 1, sel, d, 0, rq);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
    end
  end

  initial begin
    legacy_base[0] = 64'h0000_0000_1000_0000;
    legacy_base[1] = 64'h0000_0000_0000_4000;
    legacy_base[2] = 64'hFFFF_FFFF_FFFF_F000;
    legacy_base[3] = 64'h0000_0000_0020_0000;
    for (int i = 0; i < 6; i++) seg_limit[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    checks++;
    if (lin_addr !== '0 || addr_valid !== 0 || lim_fault !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %h %b %b, expected 0 0 0", lin_addr, addr_valid, lim_fault);
    end
    rst_n = 1'b1;
    // R1: bases are zero after reset
    req(1, 3'd4, 64'h1234, 4'd4, "R1 fs zero");
    req(1, 3'd5, 64'h5678, 4'd4, "R1 gs zero");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 1, "R1 swap idle");
    req(1, 3'd5, 64'h9ABC, 4'd4, "R1 kgs zero");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 1, "R10 idle");
    // R2: flat segments ignore legacy_base in 64-bit mode
    for (int t = 0; t < 4; t++) req(1, 3'(t), 64'hDEAD_BEEF_0000_0010, 4'd8, "R2 flat base");
    // R7: direct write, same-cycle request sees the old value
    step(1, 1, 3'd4, 64'h10, 4'd1, 1, 2'd0, 64'hFFFF_8000_0000_0000, 0, "R7 old value");
    req(1, 3'd4, 64'h10, 4'd1, "R7 new fs");
    wr(2'd1, 64'h0000_7FFF_0001_0000, "R7 gs write");
    // R3: FS and GS add a base, including wrap
    req(1, 3'd5, 64'h20, 4'd2, "R3 gs add");
    req(1, 3'd4, 64'h8000_0000_0000_0005, 4'd1, "R3 fs wrap");
    // R4: tiny limits do not fault in 64-bit mode
    for (int i = 0; i < 6; i++) seg_limit[i] = 32'h0000_00FF;
    req(1, 3'd3, 64'h0000_0001_0000_0000, 4'd8, "R4 no limit");
    req(1, 3'd5, 64'hFFFF_FFF0, 4'd8, "R4 no limit gs");
    // R5: all bases add in 32-bit mode, truncated to 32 bits
    for (int i = 0; i < 6; i++) seg_limit[i] = 32'hFFFF_FFFF;
    for (int t = 0; t < 6; t++) req(0, 3'(t), 64'h0000_0000_0000_2000, 4'd4, "R5 base add");
    req(0, 3'd2, 64'hABCD_0000_0000_0100, 4'd1, "R5 high offset bits");
    // R6: limit boundary
    seg_limit[3] = 32'h0000_00FF;
    req(0, 3'd3, 64'hFC, 4'd4, "R6 ends at limit");
    req(0, 3'd3, 64'hFC, 4'd5, "R6 crosses limit");
    req(0, 3'd3, 64'h100, 4'd1, "R6 past limit");
    req(0, 3'd3, 64'hFF, 4'd1, "R6 last byte");
    // R8: swap
    wr(2'd2, 64'h0000_0000_CAFE_0000, "R8 kgs write");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 1, "R8 swap");
    req(1, 3'd5, 64'h1, 4'd1, "R8 gs after swap");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 1, "R8 swap back");
    req(1, 3'd5, 64'h1, 4'd1, "R8 gs restored");
    // R9: swap and write together
    step(0, 0, 3'd0, '0, 4'd1, 1, 2'd1, 64'h0000_0000_0BAD_0000, 1, "R9 swap+gs write");
    req(1, 3'd5, 64'h2, 4'd1, "R9 gs takes write");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 1, "R9 swap again");
    req(1, 3'd5, 64'h3, 4'd1, "R9 kgs got old gs");
    step(0, 0, 3'd0, '0, 4'd1, 1, 2'd2, 64'h0000_0000_0000_7700, 1, "R9 swap+kgs write");
    req(1, 3'd5, 64'h4, 4'd1, "R9 gs after swap");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 1, "R9 swap third");
    req(1, 3'd5, 64'h5, 4'd1, "R9 kgs takes write");
    // R11: bad tags
    req(1, 3'd6, 64'h0, 4'd1, "R11 tag6 64");
    req(0, 3'd7, 64'h0, 4'd1, "R11 tag7 32");
    step(0, 0, 3'd0, '0, 4'd1, 0, 2'd0, '0, 0, "R10 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R10 results missing: got %0d pending, expected 0", q.size());
    end
    summary();
  end
endmodule